// File: doc/BRIEF.md
# Condition Flag and Interrupt Mask Register

This block holds the status byte of a small 8-bit processor core. Four result flags sit in it (half carry, negative, zero, carry/borrow), together with the global interrupt mask. Each cycle the core presents the ALU result, the carry out of the top bit, the carry out of the low nibble, and a 3-bit operation-class code. The block then updates only the flags that this class is defined to touch. Explicit commands can set or clear the carry and the mask. A full-byte load restores the register from the stack, and the current byte is always visible so it can be pushed.

The block also keeps a pending latch for the maskable interrupt lines. A request that arrives while the mask is set is remembered and is presented to the core only once the mask reads zero. Acknowledging a line clears its pending bit and sets the mask in the same edge. A separate software trap line is latched as well, but it is presented whatever the mask holds.

Top module: `ccr_core`

## Requirements
- R1: After reset `ccr_o` reads 8'hE8 (bits 7..5 and the mask at 1, all other flags at 0), and neither `irq_o` nor `trap_o` has a bit set.
- R2: Bits 7..5 of `ccr_o` read as 1 at all times, including after a load whose byte has those bits at 0.
- R3: Bit 4 (half carry) takes `alu_hcarry` on classes 1 (add) and 2 (add with carry), and no other class changes it.
- R4: Bit 2 (negative) takes bit 7 of `alu_res` on classes 1 to 6 (add, add with carry, subtract, logic, move, shift), and is unchanged on classes 0 (none) and 7 (bit test).
- R5: Bit 1 (zero) is 1 exactly when `alu_res` is all zeros on classes 1 to 6, and is unchanged on classes 0 and 7.
- R6: Bit 0 (carry/borrow) takes `alu_carry` on classes 1, 2, 3, 6 and 7, and is unchanged on classes 0, 4 and 5.
- R7: `set_c` forces carry to 1 and `clr_c` forces it to 0. Both override the operation class, and `set_c` wins when both are high.
- R8: `set_m` sets bit 3 (mask) and `clr_m` clears it, with `set_m` winning when both are high.
- R9: Any bit of `irq_ack`, or `trap_ack`, sets the mask on the same edge, even when `clr_m` is high.
- R10: `load_en` loads bits 4..0 of `ccr_o` from `load_val[4:0]` and overrides every other update in that cycle, including interrupt entry.
- R11: A pulse on `irq_req[i]` is held pending, and `irq_o[i]` is 1 only while that line is pending and the mask is 0.
- R12: `irq_ack[i]` clears the pending bit of line i on that edge, unless `irq_req[i]` is high in the same cycle, in which case the line stays pending.
- R13: `trap_req` is latched and shown on `trap_o` whatever the mask holds, and `trap_ack` clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_class | input | 3 | Operation class: 0 none, 1 add, 2 add with carry, 3 subtract, 4 logic, 5 move, 6 shift/rotate, 7 bit test |
| alu_res | input | 8 | ALU result byte |
| alu_carry | input | 1 | Carry or borrow out of the top bit |
| alu_hcarry | input | 1 | Carry from bit 3 into bit 4 |
| set_c | input | 1 | Force carry to 1 |
| clr_c | input | 1 | Force carry to 0 |
| set_m | input | 1 | Set the interrupt mask |
| clr_m | input | 1 | Clear the interrupt mask |
| load_en | input | 1 | Load the whole register (stack restore) |
| load_val | input | 8 | Byte to load, bits 7..5 ignored |
| irq_req | input | IRQ_LINES | Maskable interrupt request pulses |
| irq_ack | input | IRQ_LINES | Interrupt entry acknowledge, one bit per line |
| trap_req | input | 1 | Software trap request pulse |
| trap_ack | input | 1 | Trap entry acknowledge |
| ccr_o | output | 8 | Current register byte |
| irq_o | output | IRQ_LINES | Pending requests presented to the core |
| trap_o | output | 1 | Pending trap presented to the core |

## Verification
The hardest case to reach is a collision at the pending latch. A line's acknowledge and a fresh request on the same line can land in one cycle. The mask is set by that acknowledge, so the line remains hidden until the mask is cleared again. The stimulus first masks the block and pulses two lines. It then clears the mask and acknowledges one line while re-requesting it. Finally it clears the mask once more, so that the surviving pending bits become visible on `irq_o`.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    localparam int unsigned CCR_W  = 8;
    localparam int unsigned FLAG_W = 5;

    typedef enum logic [2:0] {
        OPC_NONE   = 3'd0,
        OPC_ADD    = 3'd1,
        OPC_ADC    = 3'd2,
        OPC_SUB    = 3'd3,
        OPC_LOGIC  = 3'd4,
        OPC_MOVE   = 3'd5,
        OPC_SHIFT  = 3'd6,
        OPC_BITTST = 3'd7
    } opc_e;

    // Field order is the byte layout of bits 4..0.
    typedef struct packed {
        logic h;
        logic m;
        logic n;
        logic z;
        logic c;
    } flags_t;

    localparam flags_t FLAGS_RST = '{h: 1'b0, m: 1'b1, n: 1'b0, z: 1'b0, c: 1'b0};

endpackage

// File: rtl/ccr_flag_next.sv
module ccr_flag_next
    import ccr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  flags_t              flags_q,
    input  logic [2:0]          op_class,
    input  logic [DATA_W-1:0]   alu_res,
    input  logic                alu_carry,
    input  logic                alu_hcarry,
    input  logic                set_c,
    input  logic                clr_c,
    input  logic                set_m,
    input  logic                clr_m,
    input  logic                entry,
    input  logic                load_en,
    input  logic [FLAG_W-1:0]   load_flags,
    output flags_t              flags_d
);

    localparam int unsigned SIGN_BIT = DATA_W - 1;

    opc_e opc;
    logic wr_h;
    logic wr_nz;
    logic wr_c;
    logic res_zero;

    always_comb begin
        opc = opc_e'(op_class);
        wr_h  = 1'b0;
        wr_nz = 1'b0;
        wr_c  = 1'b0;
        unique case (opc)
            OPC_ADD, OPC_ADC: begin wr_h = 1'b1; wr_nz = 1'b1; wr_c = 1'b1; end
            OPC_SUB:          begin wr_nz = 1'b1; wr_c = 1'b1; end
            OPC_LOGIC:        begin wr_nz = 1'b1; end
            OPC_MOVE:         begin wr_nz = 1'b1; end
            OPC_SHIFT:        begin wr_nz = 1'b1; wr_c = 1'b1; end
            OPC_BITTST:       begin wr_c = 1'b1; end
            default:          begin end
        endcase
    end

    assign res_zero = (alu_res == '0);

    always_comb begin
        flags_d = flags_q;
        if (load_en) begin
            flags_d = flags_t'(load_flags);
        end else begin
            if (wr_h) begin
                flags_d.h = alu_hcarry;
            end
            if (wr_nz) begin
                flags_d.n = alu_res[SIGN_BIT];
                flags_d.z = res_zero;
            end
            if (set_c) begin
                flags_d.c = 1'b1;
            end else if (clr_c) begin
                flags_d.c = 1'b0;
            end else if (wr_c) begin
                flags_d.c = alu_carry;
            end
            if (entry || set_m) begin
                flags_d.m = 1'b1;
            end else if (clr_m) begin
                flags_d.m = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ccr_pend_latch.sv
module ccr_pend_latch #(
    parameter int unsigned IRQ_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IRQ_LINES-1:0] irq_req,
    input  logic [IRQ_LINES-1:0] irq_ack,
    input  logic                 trap_req,
    input  logic                 trap_ack,
    input  logic                 mask,
    output logic [IRQ_LINES-1:0] irq_o,
    output logic                 trap_o
);

    typedef struct packed {
        logic [IRQ_LINES-1:0] pend;
        logic                 trap;
    } pend_t;

    pend_t st_d;
    pend_t st_q;
    logic [IRQ_LINES-1:0] pend_nxt;

    for (genvar gi = 0; gi < IRQ_LINES; gi++) begin : g_line
        // A request in the acknowledge cycle keeps the line pending.
        assign pend_nxt[gi] = irq_req[gi] | (st_q.pend[gi] & ~irq_ack[gi]);
        assign irq_o[gi]    = st_q.pend[gi] & ~mask;
    end

    always_comb begin
        st_d      = st_q;
        st_d.pend = pend_nxt;
        st_d.trap = trap_req | (st_q.trap & ~trap_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign trap_o = st_q.trap;

endmodule

// File: rtl/ccr_core.sv
module ccr_core
    import ccr_pkg::*;
#(
    parameter int unsigned IRQ_LINES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [2:0]           op_class,
    input  logic [7:0]           alu_res,
    input  logic                 alu_carry,
    input  logic                 alu_hcarry,
    input  logic                 set_c,
    input  logic                 clr_c,
    input  logic                 set_m,
    input  logic                 clr_m,
    input  logic                 load_en,
    input  logic [7:0]           load_val,
    input  logic [IRQ_LINES-1:0] irq_req,
    input  logic [IRQ_LINES-1:0] irq_ack,
    input  logic                 trap_req,
    input  logic                 trap_ack,
    output logic [7:0]           ccr_o,
    output logic [IRQ_LINES-1:0] irq_o,
    output logic                 trap_o
);

    localparam int unsigned TOP_W = CCR_W - FLAG_W;

    typedef struct packed {
        flags_t flags;
    } ccr_state_t;

    ccr_state_t st_d;
    ccr_state_t st_q;
    flags_t     flags_nxt;
    logic       entry;
    logic       unused_top_bits;

    assign entry           = (|irq_ack) | trap_ack;
    assign unused_top_bits = &load_val[CCR_W-1:FLAG_W];

    ccr_flag_next #(
        .DATA_W (CCR_W)
    ) i_flag_next (
        .flags_q    (st_q.flags),
        .op_class   (op_class),
        .alu_res    (alu_res),
        .alu_carry  (alu_carry),
        .alu_hcarry (alu_hcarry),
        .set_c      (set_c),
        .clr_c      (clr_c),
        .set_m      (set_m),
        .clr_m      (clr_m),
        .entry      (entry),
        .load_en    (load_en),
        .load_flags (load_val[FLAG_W-1:0]),
        .flags_d    (flags_nxt)
    );

    always_comb begin
        st_d       = st_q;
        st_d.flags = flags_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.flags <= FLAGS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    ccr_pend_latch #(
        .IRQ_LINES (IRQ_LINES)
    ) i_pend_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_req  (irq_req),
        .irq_ack  (irq_ack),
        .trap_req (trap_req),
        .trap_ack (trap_ack),
        .mask     (st_q.flags.m),
        .irq_o    (irq_o),
        .trap_o   (trap_o)
    );

    assign ccr_o = {{TOP_W{1'b1}}, st_q.flags};

endmodule

// File: rtl/ccr_core_chk.sv
module ccr_core_chk #(
    parameter int unsigned IRQ_LINES = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [2:0]           op_class,
    input logic [7:0]           alu_res,
    input logic                 load_en,
    input logic [7:0]           load_val,
    input logic [IRQ_LINES-1:0] irq_req,
    input logic [IRQ_LINES-1:0] irq_ack,
    input logic                 trap_req,
    input logic                 trap_ack,
    input logic [7:0]           ccr_o,
    input logic [IRQ_LINES-1:0] irq_o,
    input logic                 trap_o
);

    logic nz_class;
    logic h_class;

    assign nz_class = (op_class != 3'd0) && (op_class != 3'd7);
    assign h_class  = (op_class == 3'd1) || (op_class == 3'd2);

    assert_h_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!h_class && !load_en) |=> $stable(ccr_o[4]));

    assert_neg_copy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_class && !load_en) |=> (ccr_o[2] == $past(alu_res[7])));

    assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (nz_class && !load_en) |=> (ccr_o[1] == ($past(alu_res) == 8'h00)));

    assert_entry_masks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (((|irq_ack) || trap_ack) && !load_en) |=> ccr_o[3]);

    assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (ccr_o[4:0] == $past(load_val[4:0])));

    assert_masked_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ccr_o[3] |-> (irq_o == '0));

    assert_ack_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (|(irq_ack & ~irq_req)) |=> ((irq_o & $past(irq_ack & ~irq_req)) == '0));

    assert_trap_ack_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (trap_ack && !trap_req) |=> !trap_o);

endmodule

bind ccr_core ccr_core_chk #(
    .IRQ_LINES (IRQ_LINES)
) i_ccr_core_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_class (op_class),
    .alu_res  (alu_res),
    .load_en  (load_en),
    .load_val (load_val),
    .irq_req  (irq_req),
    .irq_ack  (irq_ack),
    .trap_req (trap_req),
    .trap_ack (trap_ack),
    .ccr_o    (ccr_o),
    .irq_o    (irq_o),
    .trap_o   (trap_o)
);

// File: tb/test_ccr_core.sv
`timescale 1ns/1ps
module test_ccr_core;

    localparam int unsigned LINES = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [2:0]       op_class;
    logic [7:0]       alu_res;
    logic             alu_carry, alu_hcarry;
    logic             set_c, clr_c, set_m, clr_m;
    logic             load_en;
    logic [7:0]       load_val;
    logic [LINES-1:0] irq_req, irq_ack;
    logic             trap_req, trap_ack;
    logic [7:0]       ccr_o;
    logic [LINES-1:0] irq_o;
    logic             trap_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    ccr_core #(.IRQ_LINES(LINES)) i_ccr_core (
        .clk(clk), .rst_n(rst_n), .op_class(op_class), .alu_res(alu_res),
        .alu_carry(alu_carry), .alu_hcarry(alu_hcarry), .set_c(set_c),
        .clr_c(clr_c), .set_m(set_m), .clr_m(clr_m), .load_en(load_en),
        .load_val(load_val), .irq_req(irq_req), .irq_ack(irq_ack),
        .trap_req(trap_req), .trap_ack(trap_ack), .ccr_o(ccr_o),
        .irq_o(irq_o), .trap_o(trap_o)
    );

    task automatic idle();
        op_class = 3'd0; alu_res = 8'h00; alu_carry = 1'b0; alu_hcarry = 1'b0;
        set_c = 1'b0; clr_c = 1'b0; set_m = 1'b0; clr_m = 1'b0;
        load_en = 1'b0; load_val = 8'h00; irq_req = '0; irq_ack = '0;
        trap_req = 1'b0; trap_ack = 1'b0;
    endtask

    // Inputs set by the caller are taken on the next edge; outputs sampled 1 ns later.
    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic alu_op(logic [2:0] opc, logic [7:0] res, logic cy, logic hc);
        op_class = opc; alu_res = res; alu_carry = cy; alu_hcarry = hc;
        tick();
    endtask

    task automatic t_reset();
        check("R1 ccr", ccr_o, 8'hE8);
        check("R1 irq", irq_o, '0);
        check("R1 trap", trap_o, 1'b0);
    endtask

    task automatic t_classes();
        alu_op(3'd1, 8'h00, 1'b1, 1'b1); check("R3 R5 R6 add", ccr_o, 8'hFB);
        alu_op(3'd3, 8'h80, 1'b0, 1'b0); check("R3 R4 sub keeps H", ccr_o, 8'hFC);
        alu_op(3'd4, 8'h00, 1'b1, 1'b0); check("R5 R6 logic keeps C", ccr_o, 8'hFA);
        alu_op(3'd7, 8'h80, 1'b1, 1'b0); check("R4 R6 bittest only C", ccr_o, 8'hFB);
        alu_op(3'd5, 8'h7F, 1'b0, 1'b0); check("R4 R5 move", ccr_o, 8'hF9);
        alu_op(3'd2, 8'h10, 1'b0, 1'b0); check("R3 adc clears H", ccr_o, 8'hE8);
        alu_op(3'd6, 8'hC0, 1'b1, 1'b1); check("R4 R6 shift", ccr_o, 8'hED);
        alu_op(3'd0, 8'h00, 1'b0, 1'b1); check("R3 R4 R5 none", ccr_o, 8'hED);
    endtask

    task automatic t_carry_cmds();
        set_c = 1'b1; op_class = 3'd1; alu_res = 8'h01; tick();
        check("R7 set_c over add", ccr_o, 8'hE9);
        clr_c = 1'b1; op_class = 3'd6; alu_res = 8'h01; alu_carry = 1'b1; tick();
        check("R7 clr_c over shift", ccr_o, 8'hE8);
        set_c = 1'b1; clr_c = 1'b1; tick();
        check("R7 set_c wins", ccr_o, 8'hE9);
    endtask

    task automatic t_mask();
        clr_m = 1'b1; tick();           check("R8 clr_m", ccr_o, 8'hE1);
        set_m = 1'b1; clr_m = 1'b1; tick(); check("R8 set_m wins", ccr_o, 8'hE9);
        clr_m = 1'b1; tick();           check("R8 clr_m again", ccr_o, 8'hE1);
        clr_m = 1'b1; irq_ack = 4'b0010; tick();
        check("R9 ack over clr_m", ccr_o[3], 1'b1);
    endtask

    task automatic t_load();
        load_en = 1'b1; load_val = 8'h00; set_c = 1'b1; set_m = 1'b1; tick();
        check("R10 R2 load zero", ccr_o, 8'hE0);
        load_en = 1'b1; load_val = 8'hFF; op_class = 3'd1; tick();
        check("R10 load ones", ccr_o, 8'hFF);
        load_en = 1'b1; load_val = 8'h15; tick();
        check("R10 R2 load 15", ccr_o, 8'hF5);
        load_en = 1'b1; load_val = 8'h00; irq_ack = 4'b0001; trap_ack = 1'b1; tick();
        check("R10 load over entry", ccr_o, 8'hE0);
    endtask

    task automatic t_pending();
        set_m = 1'b1; tick();
        irq_req = 4'b0101; tick();
        check("R11 masked hidden", irq_o, 4'b0000);
        clr_m = 1'b1; tick();
        check("R11 shown after unmask", irq_o, 4'b0101);
        irq_ack = 4'b0001; tick();
        check("R9 ack masks", ccr_o[3], 1'b1);
        check("R11 hidden during entry", irq_o, 4'b0000);
        clr_m = 1'b1; tick();
        check("R12 line0 cleared", irq_o, 4'b0100);
        irq_ack = 4'b0100; irq_req = 4'b0100; tick();
        clr_m = 1'b1; tick();
        check("R12 collision keeps pending", irq_o, 4'b0100);
        irq_ack = 4'b0100; tick();
        clr_m = 1'b1; tick();
        check("R12 line2 cleared", irq_o, 4'b0000);
    endtask

    task automatic t_trap();
        set_m = 1'b1; tick();
        trap_req = 1'b1; tick();
        check("R13 trap ignores mask", trap_o, 1'b1);
        trap_ack = 1'b1; clr_m = 1'b1; tick();
        check("R13 trap cleared", trap_o, 1'b0);
        check("R9 trap entry masks", ccr_o[3], 1'b1);
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        t_reset();
        t_classes();
        t_carry_cmds();
        t_mask();
        t_load();
        t_pending();
        t_trap();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

endmodule